// File: doc/BRIEF.md
# Transform-Domain Integer Motion Peak Finder

This block takes the two square arrays that an inverse pseudo-phase transform produces for one image block. It finds the single entry whose magnitude is largest across both arrays and turns that entry into a signed integer motion vector. Each array corresponds to one pairing of displacement signs. The entry's row and column indices give the size of the vertical and horizontal shift. The array it came from, together with the sign of its value, picks the compass quadrant. No block-matching search is involved. The decision is a running maximum taken as the samples stream past.

Samples arrive one per accepted cycle. Each sample carries an array tag, its row and column, and a signed value. A block is opened by a start strobe, and it holds exactly 2·N·N accepted samples. Once the final sample is taken, the block reports the vector with a one-cycle done pulse. If the winning shift reaches past a configurable boundary, the block reports the zero vector and raises a fallback flag instead. The block edge length N, the sample width and the boundary are all parameters.

Top module: `pk_motion_peak`

## Requirements
- R1: After reset, res_done, res_dx, res_dy and res_fallback are all 0.
- R2: The reported entry is the one with the largest absolute value over all 2·N·N samples of both arrays. Its column index is |res_dx| and its row index is |res_dy|.
- R3: When several entries share the largest magnitude, the one accepted first in arrival order wins.
- R4: For a peak in array 0 (smp_arr = 0), a non-negative value gives positive dx and dy (north-east), and a negative value gives negative dx and dy (south-west).
- R5: For a peak in array 1 (smp_arr = 1), a non-negative value gives positive dx and negative dy, and a negative value gives negative dx and positive dy.
- R6: If the peak row or column exceeds BOUND (default N-2 = 6), the block reports dx = dy = 0 and res_fallback = 1. Otherwise res_fallback = 0.
- R7: res_done is high for exactly one cycle: the cycle after the edge at which the 2·N·N-th sample of the block is accepted. The vector outputs change only on that edge and hold their value between results.
- R8: A cycle with smp_valid low has no effect, whatever the other inputs carry. A valid sample that arrives outside an open block is also ignored: it neither counts toward a block nor influences a result.
- R9: A start strobe during an open block discards everything accepted so far and begins a new block. A sample presented in the same cycle as start is the first sample of the new block.
- R10: The most negative sample value (-2048 for 12 bits) counts as magnitude 2048, so it beats +2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| blk_start | input | 1 | Opens a new block (restarts one already open) |
| smp_valid | input | 1 | Sample on the inputs is presented this cycle |
| smp_arr | input | 1 | Array tag: 0 or 1 |
| smp_row | input | $clog2(N) | Row index of the sample |
| smp_col | input | $clog2(N) | Column index of the sample |
| smp_val | input | W | Signed sample value |
| res_done | output | 1 | One-cycle pulse, result ready |
| res_dx | output | $clog2(N)+1 | Signed horizontal shift, east positive |
| res_dy | output | $clog2(N)+1 | Signed vertical shift, north positive |
| res_fallback | output | 1 | Peak was beyond BOUND; vector forced to zero |

## Verification
The assertions check several properties on every cycle:
- the done pulse never lasts two cycles and always follows a presented sample;
- the vector is frozen whenever done is low;
- a fallback result always carries the zero vector;
- a non-fallback result never exceeds BOUND.

Only the bench's scenarios can show that the chosen entry is the true magnitude maximum with first-come tie breaking, and that the quadrant follows the array tag and sign. The same holds for idle-cycle garbage, samples outside a block and a mid-block restart having no influence, and for full-scale negative values winning.

// File: rtl/pk_pkg.sv
package pk_pkg;

  typedef enum logic {
    ARR_SAME = 1'b0,
    ARR_OPP  = 1'b1
  } arr_tag_e;

endpackage

// File: rtl/pk_scan_ctrl.sv
module pk_scan_ctrl #(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic valid,
  output logic accept,
  output logic first,
  output logic last
);
  localparam int TOTAL = 2 * N * N;
  localparam int CW    = $clog2(TOTAL + 1);

  logic          active;
  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_eff;

  // a start strobe rewinds the count in the same cycle
  assign cnt_eff = start ? '0 : cnt;
  assign accept  = valid && (active || start);
  assign first   = accept && (cnt_eff == '0);
  assign last    = accept && (cnt_eff == CW'(TOTAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (accept) begin
      active <= !last;
      cnt    <= last ? '0 : cnt_eff + CW'(1);
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end
  end

endmodule

// File: rtl/pk_max_track.sv
module pk_max_track
  import pk_pkg::*;
#(
  parameter int W  = 12,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          first,
  input  arr_tag_e      arr,
  input  logic [IW-1:0] row,
  input  logic [IW-1:0] col,
  input  logic [W-1:0]  val,
  output logic          take,
  output arr_tag_e      cand_arr,
  output logic [IW-1:0] cand_row,
  output logic [IW-1:0] cand_col,
  output logic          cand_neg
);
  // unsigned magnitude; the full-scale negative maps to 2^(W-1)
  function automatic logic [W-1:0] mag_of(input logic [W-1:0] v);
    return v[W-1] ? (~v + W'(1)) : v;
  endfunction

  logic [W-1:0]  best_mag;
  arr_tag_e      best_arr;
  logic [IW-1:0] best_row;
  logic [IW-1:0] best_col;
  logic          best_neg;
  logic [W-1:0]  new_mag;

  assign new_mag = mag_of(val);
  // strict compare keeps the earliest of equal peaks
  assign take    = accept && (first || (new_mag > best_mag));

  always_comb begin
    if (take) begin
      cand_arr = arr;
      cand_row = row;
      cand_col = col;
      cand_neg = val[W-1];
    end else begin
      cand_arr = best_arr;
      cand_row = best_row;
      cand_col = best_col;
      cand_neg = best_neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best_mag <= '0;
      best_arr <= ARR_SAME;
      best_row <= '0;
      best_col <= '0;
      best_neg <= 1'b0;
    end else if (take) begin
      best_mag <= new_mag;
      best_arr <= arr;
      best_row <= row;
      best_col <= col;
      best_neg <= val[W-1];
    end
  end

endmodule

// File: rtl/pk_vec_form.sv
module pk_vec_form
  import pk_pkg::*;
#(
  parameter int IW    = 3,
  parameter int VW    = 4,
  parameter int BOUND = 6
) (
  input  arr_tag_e      arr,
  input  logic [IW-1:0] row,
  input  logic [IW-1:0] col,
  input  logic          neg,
  output logic [VW-1:0] dx,
  output logic [VW-1:0] dy,
  output logic          fallback
);
  function automatic logic [VW-1:0] apply_sign(input logic [IW-1:0] m,
                                               input logic          flip);
    logic [VW-1:0] wide;
    wide = {1'b0, m};
    return flip ? (~wide + VW'(1)) : wide;
  endfunction

  logic x_neg;
  logic y_neg;

  assign x_neg    = neg;
  // array 0 moves both axes together, array 1 moves them oppositely
  assign y_neg    = (arr == ARR_SAME) ? neg : !neg;
  assign fallback = (int'(row) > BOUND) || (int'(col) > BOUND);

  always_comb begin
    if (fallback) begin
      dx = '0;
      dy = '0;
    end else begin
      dx = apply_sign(col, x_neg);
      dy = apply_sign(row, y_neg);
    end
  end

endmodule

// File: rtl/pk_motion_peak.sv
module pk_motion_peak
  import pk_pkg::*;
#(
  parameter int N     = 8,
  parameter int W     = 12,
  parameter int BOUND = N - 2,
  parameter int IW    = $clog2(N),
  parameter int VW    = IW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          blk_start,
  input  logic          smp_valid,
  input  logic          smp_arr,
  input  logic [IW-1:0] smp_row,
  input  logic [IW-1:0] smp_col,
  input  logic [W-1:0]  smp_val,
  output logic          res_done,
  output logic [VW-1:0] res_dx,
  output logic [VW-1:0] res_dy,
  output logic          res_fallback
);
  logic          ev_accept;
  logic          ev_first;
  logic          ev_last;
  logic          ev_take;
  arr_tag_e      cand_arr;
  logic [IW-1:0] cand_row;
  logic [IW-1:0] cand_col;
  logic          cand_neg;
  logic [VW-1:0] nx_dx;
  logic [VW-1:0] nx_dy;
  logic          nx_fb;

  pk_scan_ctrl #(.N(N)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (blk_start),
    .valid  (smp_valid),
    .accept (ev_accept),
    .first  (ev_first),
    .last   (ev_last)
  );

  pk_max_track #(.W(W), .IW(IW)) u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (ev_accept),
    .first    (ev_first),
    .arr      (arr_tag_e'(smp_arr)),
    .row      (smp_row),
    .col      (smp_col),
    .val      (smp_val),
    .take     (ev_take),
    .cand_arr (cand_arr),
    .cand_row (cand_row),
    .cand_col (cand_col),
    .cand_neg (cand_neg)
  );

  pk_vec_form #(.IW(IW), .VW(VW), .BOUND(BOUND)) u_vec (
    .arr      (cand_arr),
    .row      (cand_row),
    .col      (cand_col),
    .neg      (cand_neg),
    .dx       (nx_dx),
    .dy       (nx_dy),
    .fallback (nx_fb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_done     <= 1'b0;
      res_dx       <= '0;
      res_dy       <= '0;
      res_fallback <= 1'b0;
    end else begin
      res_done <= ev_last;
      if (ev_last) begin
        res_dx       <= nx_dx;
        res_dy       <= nx_dy;
        res_fallback <= nx_fb;
      end
    end
  end

endmodule

// File: rtl/pk_peak_chk.sv
module pk_peak_chk #(
  parameter int BOUND = 6,
  parameter int VW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          smp_valid,
  input logic          ev_take,
  input logic          ev_accept,
  input logic          res_done,
  input logic [VW-1:0] res_dx,
  input logic [VW-1:0] res_dy,
  input logic          res_fallback
);
  logic [VW-1:0] adx;
  logic [VW-1:0] ady;

  always_comb begin
    adx = res_dx[VW-1] ? (~res_dx + VW'(1)) : res_dx;
    ady = res_dy[VW-1] ? (~res_dy + VW'(1)) : res_dy;
  end

  // R7: done never lasts two cycles (a block holds at least two samples)
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |=> !res_done);

  // R7: vector outputs move only together with done
  a_r7_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !res_done |-> ($stable(res_dx) && $stable(res_dy) && $stable(res_fallback)));

  // R8: a result follows a cycle in which a sample was presented
  a_r8_done_after_valid: assert property (@(posedge clk) disable iff (!rst_n)
    res_done |-> $past(smp_valid));

  // R8: the tracker only updates on an accepted sample
  a_r8_take_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
    ev_take |-> ev_accept);

  // R6: fallback always carries the zero vector
  a_r6_fallback_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && res_fallback) |-> (res_dx == '0 && res_dy == '0));

  // R2: a normal result never exceeds the boundary
  a_r2_within_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (res_done && !res_fallback) |-> (int'(adx) <= BOUND && int'(ady) <= BOUND));

endmodule

bind pk_motion_peak pk_peak_chk #(.BOUND(BOUND), .VW(VW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .smp_valid    (smp_valid),
  .ev_take      (ev_take),
  .ev_accept    (ev_accept),
  .res_done     (res_done),
  .res_dx       (res_dx),
  .res_dy       (res_dy),
  .res_fallback (res_fallback)
);

// File: tb/sim_pk_motion_peak.sv
`timescale 1ns/1ps
module sim_pk_motion_peak;
  localparam int N     = 8;
  localparam int W     = 12;
  localparam int BOUND = N - 2;
  localparam int IW    = 3;
  localparam int VW    = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          blk_start = 1'b0;
  logic          smp_valid = 1'b0;
  logic          smp_arr = 1'b0;
  logic [IW-1:0] smp_row = '0;
  logic [IW-1:0] smp_col = '0;
  logic [W-1:0]  smp_val = '0;
  logic          res_done;
  logic [VW-1:0] res_dx;
  logic [VW-1:0] res_dy;
  logic          res_fallback;

  int n_chk = 0;
  int n_bad = 0;
  int n_done = 0;
  int cycles = 0;

  int blk [0:1][0:N-1][0:N-1];
  int e_dx, e_dy, e_fb;

  always #4 clk = ~clk;

  pk_motion_peak #(.N(N), .W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .blk_start(blk_start), .smp_valid(smp_valid),
    .smp_arr(smp_arr), .smp_row(smp_row), .smp_col(smp_col), .smp_val(smp_val),
    .res_done(res_done), .res_dx(res_dx), .res_dy(res_dy), .res_fallback(res_fallback)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (res_done) n_done <= n_done + 1;
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absv(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // expected result: scan order array 0 then array 1, both raster
  task automatic model();
    int bm, ba, br, bc, bv;
    bm = -1; ba = 0; br = 0; bc = 0; bv = 0;
    for (int a = 0; a < 2; a++)
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          if (absv(blk[a][r][c]) > bm) begin
            bm = absv(blk[a][r][c]); ba = a; br = r; bc = c; bv = blk[a][r][c];
          end
    if (br > BOUND || bc > BOUND) begin
      e_dx = 0; e_dy = 0; e_fb = 1;
    end else begin
      e_fb = 0;
      e_dx = (bv < 0) ? -bc : bc;
      if (ba == 0) e_dy = (bv < 0) ? -br : br;
      else         e_dy = (bv < 0) ? br : -br;
    end
  endtask

  task automatic fill_rand(input int lim);
    for (int a = 0; a < 2; a++)
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++)
          blk[a][r][c] = $urandom_range(0, 2 * lim) - lim;
  endtask

  task automatic idle_garbage();
    smp_valid = 1'b0;
    blk_start = 1'b0;
    smp_val   = 12'h800;
    smp_arr   = 1'b1;
    smp_row   = 3'd3;
    smp_col   = 3'd3;
  endtask

  // feeds count samples; gaps inserts idle cycles carrying garbage (R8)
  task automatic feed(input int count, input bit gaps, input bit pre_start);
    int k;
    k = 0;
    if (pre_start) begin
      @(negedge clk); idle_garbage(); blk_start = 1'b1;
    end
    for (int a = 0; a < 2; a++)
      for (int r = 0; r < N; r++)
        for (int c = 0; c < N; c++) begin
          if (k < count) begin
            if (gaps && $urandom_range(0, 3) == 0) begin
              @(negedge clk); idle_garbage();
            end
            @(negedge clk);
            blk_start = (k == 0) && !pre_start;
            smp_valid = 1'b1;
            smp_arr   = a[0];
            smp_row   = r[IW-1:0];
            smp_col   = c[IW-1:0];
            smp_val   = blk[a][r][c][W-1:0];
            k++;
          end
        end
    @(negedge clk); idle_garbage();
  endtask

  task automatic run_check(input string req, input bit gaps, input bit pre);
    int d0;
    model();
    d0 = n_done;
    feed(2 * N * N, gaps, pre);
    check({req, " done pulse"}, int'(res_done), 1);
    check({req, " dx"}, int'($signed(res_dx)), e_dx);
    check({req, " dy"}, int'($signed(res_dy)), e_dy);
    check({req, " fallback"}, int'(res_fallback), e_fb);
    @(negedge clk);
    check("R7 done drops", int'(res_done), 0);
    check("R7 single pulse", n_done - d0, 1);
    check("R7 dx held", int'($signed(res_dx)), e_dx);
  endtask

  task automatic place(input int a, input int r, input int c, input int v);
    fill_rand(50);
    blk[a][r][c] = v;
  endtask

  initial begin
    int sd;
    int hold_dx, hold_dy, hold_fb, d0;
    sd = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    check("R1 done", int'(res_done), 0);
    check("R1 dx", int'(res_dx), 0);
    check("R1 dy", int'(res_dy), 0);
    check("R1 fallback", int'(res_fallback), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 random blocks, gaps and both start styles (R8, R9 same-cycle start)
    for (int i = 0; i < 24; i++) begin
      fill_rand(2047);
      run_check("R2 random", (i % 2) == 1, (i % 3) == 0);
    end

    // R4 / R5 quadrants
    place(0, 2, 3, 900);   run_check("R4 array0 positive", 1'b0, 1'b0);
    place(0, 4, 1, -900);  run_check("R4 array0 negative", 1'b0, 1'b0);
    place(1, 5, 2, 900);   run_check("R5 array1 positive", 1'b0, 1'b0);
    place(1, 1, 6, -900);  run_check("R5 array1 negative", 1'b1, 1'b0);

    // R3 tie: earlier in scan order wins (array 0 beats array 1)
    place(1, 1, 1, -700);
    blk[0][5][4] = 700;
    run_check("R3 tie first kept", 1'b0, 1'b0);
    check("R3 tie dx", int'($signed(res_dx)), 4);

    // R6 boundary
    place(0, 7, 2, 1000);  run_check("R6 row beyond", 1'b0, 1'b0);
    check("R6 flag row", int'(res_fallback), 1);
    place(1, 0, 7, -1000); run_check("R6 col beyond", 1'b0, 1'b0);
    place(1, 6, 6, -1000); run_check("R6 at bound", 1'b0, 1'b0);
    check("R6 flag clear", int'(res_fallback), 0);

    // R10 full-scale negative beats +2047
    place(0, 3, 3, 2047);
    blk[1][2][5] = -2048;
    run_check("R10 full scale", 1'b0, 1'b0);

    // R8 valid samples outside a block are ignored
    hold_dx = int'(res_dx); hold_dy = int'(res_dy); hold_fb = int'(res_fallback);
    d0 = n_done;
    for (int k = 0; k < 2 * N * N + 5; k++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_arr = 1'b1; smp_row = 3'd2; smp_col = 3'd2;
      smp_val = 12'h7FF;
    end
    @(negedge clk); idle_garbage();
    @(negedge clk);
    check("R8 no done outside block", n_done - d0, 0);
    check("R8 dx unchanged", int'(res_dx), hold_dx);
    check("R8 dy unchanged", int'(res_dy), hold_dy);
    check("R8 fallback unchanged", int'(res_fallback), hold_fb);

    // R9 restart discards partial block holding a big peak
    place(0, 1, 2, -2048);
    d0 = n_done;
    feed(30, 1'b0, 1'b0);
    check("R9 no done on partial", n_done - d0, 0);
    place(1, 3, 4, 1500);
    run_check("R9 restart", 1'b1, 1'b0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule